// File: doc/BRIEF.md
# Multithreaded Rename Rollback Unit

This block owns the register-renaming state of a multithreaded out-of-order core. It has one physical-register free list that all hardware threads share. Each thread also has its own architectural-to-physical map and a history stack of the renamings it has made. A rename request takes the lowest-numbered free physical register for one thread. It records the earlier mapping of that architectural register in the thread's history and updates the map.

When a thread is squashed, the unit rolls back every renaming of that thread that is younger than the squash sequence number. It works from the youngest entry, one per cycle, and puts each earlier mapping back. The physical registers freed by the rollback do not return to the shared free list straight away. Instructions that were squashed but are still in flight may hold them, and another thread could otherwise be given one of them. They are parked in a per-thread holding stack instead. The holding stack is emptied into the free list only in cycles where commit reports that the thread's reorder-buffer squash has finished.

A thread that has a rollback in progress or parked registers cannot rename. The other threads keep renaming from whatever is free.

Top module: `rsq_rename_recovery`

## Requirements
- R1: After a synchronous reset, thread t maps architectural register a to physical register t*NUM_ARCH+a. Every higher physical register is free, so free_count equals NUM_PHYS-NUM_THREADS*NUM_ARCH. No thread is stalled.
- R2: alloc_grant is high in the same cycle as alloc_valid when all of these hold: the thread is not stalled, its history is not full and the free list is not empty. On a grant, alloc_preg is the lowest-numbered free register. From the next cycle the thread's map sends alloc_arch to that register, and the register is no longer counted as free.
- R3: free_empty is high exactly when no physical register is free. While it is high, no request is granted.
- R4: A thread holding HIST_DEPTH unretired-by-squash renamings in its history is refused further allocation.
- R5: The rollback starts in the cycle after squash_valid is accepted for a thread. In each cycle it undoes the youngest history entry whose sequence number is greater than the squash sequence number (unsigned comparison), and that entry's architectural register maps back to its previous physical register. The rollback stops at the first entry that is not younger, or when the history is empty.
- R6: Registers undone by a rollback are not added to free_count while the rollback runs. They are parked in that thread's holding stack.
- R7: Parked registers of thread t return to the free list in cycles where all of these hold: commit_squashing[t] is low, no rollback is running for t, and no squash request for t is present. At most DRAIN_W registers return per cycle. While commit_squashing[t] stays high, the parked registers stay unavailable.
- R8: thread_stall[t] is high whenever one of these holds: a squash request for t is present, a rollback for t is running, or t has parked registers. A stalled thread's request is refused, and other threads keep being granted.
- R9: A squash or drain of one thread leaves the map and history of every other thread unchanged.
- R10: A squash request that arrives for a thread whose rollback is still running replaces that thread's squash point, and the rollback continues toward the new point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Rename request |
| alloc_tid | input | TID_W | Requesting thread |
| alloc_arch | input | ARCH_W | Architectural destination register |
| alloc_seq | input | SEQ_W | Sequence number of the renaming instruction |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_preg | output | PREG_W | Physical register given on a grant |
| free_empty | output | 1 | No physical register free |
| free_count | output | CNT_W | Number of free physical registers |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Thread being squashed |
| squash_seq | input | SEQ_W | Squash point; younger renamings are undone |
| commit_squashing | input | NUM_THREADS | Per-thread reorder-buffer squash still in progress |
| thread_stall | output | NUM_THREADS | Per-thread rename stall |
| lookup_tid | input | TID_W | Map read thread |
| lookup_arch | input | ARCH_W | Map read architectural register |
| lookup_preg | output | PREG_W | Current mapping of the read register |

## Verification
Two things meet in one cycle. One thread's parked registers drain back into the shared free list while another thread is making a rename request. This is provoked by running a rollback on one thread while the other thread keeps asking for registers against an empty free list. The commit status is then dropped for the rolled-back thread. A behavioural model checks that the requesting thread is given the lowest register that was free before that clock edge, and never one being released in the same edge. It also checks that free_count settles to the sum of both effects. A long random phase also drives squash requests into running rollbacks and overlaps drains with renames.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int unsigned DEF_THREADS = 2;
    localparam int unsigned DEF_ARCH    = 4;
    localparam int unsigned DEF_PHYS    = 15;
    localparam int unsigned DEF_HIST    = 4;
    localparam int unsigned DEF_DRAIN   = 2;
    localparam int unsigned DEF_SEQ_W   = 16;

    // Context phase of one hardware thread.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // free to rename
        PH_WALK   = 2'd1,  // rolling back history
        PH_PARKED = 2'd2   // holding released registers
    } ctx_phase_e;

    // Physical register a thread's architectural register maps to at reset.
    function automatic int unsigned home_preg(int unsigned tid, int unsigned arch,
                                              int unsigned n_arch);
        return tid * n_arch + arch;
    endfunction

    function automatic int unsigned safe_clog2(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rsq_free_list.sv
module rsq_free_list
    import rsq_pkg::*;
#(
    parameter int unsigned NUM_PHYS  = DEF_PHYS,
    parameter int unsigned HOME_REGS = DEF_THREADS * DEF_ARCH,
    parameter int unsigned N_REL     = DEF_THREADS * DEF_DRAIN,
    localparam int unsigned PREG_W   = safe_clog2(NUM_PHYS),
    localparam int unsigned CNT_W    = $clog2(NUM_PHYS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         take,
    input  logic [N_REL-1:0]             rel_valid,
    input  logic [N_REL-1:0][PREG_W-1:0] rel_preg,
    output logic [PREG_W-1:0]            head_preg,
    output logic                         empty,
    output logic [CNT_W-1:0]             count
);

    logic [NUM_PHYS-1:0] free_q;
    logic [NUM_PHYS-1:0] take_mask;
    logic [NUM_PHYS-1:0] rel_mask;

    // Lowest-numbered free register wins.
    always_comb begin
        head_preg = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_q[i]) head_preg = PREG_W'(i);
        end
    end

    assign empty = ~|free_q;

    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_PHYS; i++) count = count + CNT_W'(free_q[i]);
    end

    always_comb begin
        take_mask = take ? (NUM_PHYS'(1) << head_preg) : '0;
        rel_mask  = '0;
        for (int k = 0; k < int'(N_REL); k++) begin
            if (rel_valid[k]) rel_mask = rel_mask | (NUM_PHYS'(1) << rel_preg[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= int'(HOME_REGS));
        end else begin
            free_q <= (free_q & ~take_mask) | rel_mask;
        end
    end

    // A released register must be one that is currently owned.
    assert_no_double_release_R6: assert property (@(posedge clk) disable iff (rst)
        (rel_mask & free_q) == '0);

    // Nothing is taken from an empty list.
    assert_take_needs_free_R3: assert property (@(posedge clk) disable iff (rst)
        take |-> !empty);

endmodule

// File: rtl/rsq_thread_ctx.sv
module rsq_thread_ctx
    import rsq_pkg::*;
#(
    parameter int unsigned TID        = 0,
    parameter int unsigned NUM_ARCH   = DEF_ARCH,
    parameter int unsigned NUM_PHYS   = DEF_PHYS,
    parameter int unsigned HIST_DEPTH = DEF_HIST,
    parameter int unsigned DRAIN_W    = DEF_DRAIN,
    parameter int unsigned SEQ_W      = DEF_SEQ_W,
    localparam int unsigned PREG_W    = safe_clog2(NUM_PHYS),
    localparam int unsigned ARCH_W    = safe_clog2(NUM_ARCH),
    localparam int unsigned HIDX_W    = safe_clog2(HIST_DEPTH),
    localparam int unsigned HCNT_W    = $clog2(HIST_DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           alloc_fire,
    input  logic [ARCH_W-1:0]              alloc_arch,
    input  logic [SEQ_W-1:0]               alloc_seq,
    input  logic [PREG_W-1:0]              alloc_preg,
    input  logic                           squash_hit,
    input  logic [SEQ_W-1:0]               squash_seq,
    input  logic                           commit_squashing,
    input  logic [ARCH_W-1:0]              lookup_arch,
    output logic [PREG_W-1:0]              lookup_preg,
    output logic                           stall,
    output logic                           hist_full,
    output logic [DRAIN_W-1:0]             rel_valid,
    output logic [DRAIN_W-1:0][PREG_W-1:0] rel_preg
);

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [ARCH_W-1:0] arch;
        logic [PREG_W-1:0] prev_preg;
        logic [PREG_W-1:0] new_preg;
    } hist_ent_t;

    ctx_phase_e                   phase_q, phase_d;
    logic [NUM_ARCH-1:0][PREG_W-1:0] map_q;
    hist_ent_t                    hist_q [HIST_DEPTH];
    logic [PREG_W-1:0]            pend_q [HIST_DEPTH];
    logic [HCNT_W-1:0]            hist_cnt_q;
    logic [HCNT_W-1:0]            pend_cnt_q;
    logic [SEQ_W-1:0]             point_q;

    hist_ent_t                    top_ent;
    logic                         pop_ok;
    logic                         drain_ok;
    logic [HCNT_W-1:0]            drain_n;

    always_comb begin
        top_ent = '0;
        for (int i = 0; i < HIST_DEPTH; i++) begin
            if (HCNT_W'(i + 1) == hist_cnt_q) top_ent = hist_q[i];
        end
    end

    assign pop_ok    = (phase_q == PH_WALK) && (hist_cnt_q != '0) && (top_ent.seq > point_q);
    assign drain_ok  = (phase_q == PH_PARKED) && !squash_hit && !commit_squashing;
    assign drain_n   = (pend_cnt_q > HCNT_W'(DRAIN_W)) ? HCNT_W'(DRAIN_W) : pend_cnt_q;
    assign stall     = squash_hit || (phase_q != PH_IDLE);
    assign hist_full = (hist_cnt_q == HCNT_W'(HIST_DEPTH));
    assign lookup_preg = map_q[lookup_arch];

    // Release ports read the holding stack from its top downward.
    always_comb begin
        for (int k = 0; k < int'(DRAIN_W); k++) begin
            rel_valid[k] = drain_ok && (k < int'(pend_cnt_q));
            rel_preg[k]  = '0;
            for (int i = 0; i < HIST_DEPTH; i++) begin
                if (i + 1 + k == int'(pend_cnt_q)) rel_preg[k] = pend_q[i];
            end
        end
    end

    always_comb begin
        phase_d = phase_q;
        if (squash_hit) begin
            phase_d = PH_WALK;
        end else begin
            case (phase_q)
                PH_WALK:   if (!pop_ok) phase_d = (pend_cnt_q != '0) ? PH_PARKED : PH_IDLE;
                PH_PARKED: if (drain_ok && (pend_cnt_q <= HCNT_W'(DRAIN_W))) phase_d = PH_IDLE;
                default:   phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            hist_cnt_q <= '0;
            pend_cnt_q <= '0;
            point_q    <= '0;
            for (int a = 0; a < NUM_ARCH; a++) begin
                map_q[a] <= PREG_W'(home_preg(TID, a, NUM_ARCH));
            end
        end else begin
            phase_q <= phase_d;
            if (squash_hit) point_q <= squash_seq;
            if (alloc_fire) begin
                map_q[alloc_arch] <= alloc_preg;
                hist_cnt_q        <= hist_cnt_q + 1'b1;
            end else if (pop_ok) begin
                map_q[top_ent.arch] <= top_ent.prev_preg;
                hist_cnt_q          <= hist_cnt_q - 1'b1;
            end
            if (pop_ok) begin
                pend_cnt_q <= pend_cnt_q + 1'b1;
            end else if (drain_ok) begin
                pend_cnt_q <= pend_cnt_q - drain_n;
            end
        end
    end

    // Storage arrays carry no reset; the counters qualify them.
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            hist_q[HIDX_W'(hist_cnt_q)] <= '{seq: alloc_seq, arch: alloc_arch,
                                             prev_preg: map_q[alloc_arch],
                                             new_preg: alloc_preg};
        end
        if (pop_ok) pend_q[HIDX_W'(pend_cnt_q)] <= top_ent.new_preg;
    end

    // The parent never fires a full history.
    assert_hist_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |-> !hist_full);

    // Renaming happens only in an idle context.
    assert_fire_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |-> (phase_q == PH_IDLE));

    // History plus parked registers never exceed one history's worth.
    assert_pend_capacity_R6: assert property (@(posedge clk) disable iff (rst)
        (32'(hist_cnt_q) + 32'(pend_cnt_q)) <= HIST_DEPTH);

    // A drain step strictly shrinks the holding stack.
    assert_drain_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
        (|rel_valid) |=> (pend_cnt_q < $past(pend_cnt_q)));

endmodule

// File: rtl/rsq_rename_recovery.sv
module rsq_rename_recovery
    import rsq_pkg::*;
#(
    parameter int unsigned NUM_THREADS = DEF_THREADS,
    parameter int unsigned NUM_ARCH    = DEF_ARCH,
    parameter int unsigned NUM_PHYS    = DEF_PHYS,
    parameter int unsigned HIST_DEPTH  = DEF_HIST,
    parameter int unsigned DRAIN_W     = DEF_DRAIN,
    parameter int unsigned SEQ_W       = DEF_SEQ_W,
    localparam int unsigned TID_W      = safe_clog2(NUM_THREADS),
    localparam int unsigned ARCH_W     = safe_clog2(NUM_ARCH),
    localparam int unsigned PREG_W     = safe_clog2(NUM_PHYS),
    localparam int unsigned CNT_W      = $clog2(NUM_PHYS + 1),
    localparam int unsigned N_REL      = NUM_THREADS * DRAIN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_valid,
    input  logic [TID_W-1:0]       alloc_tid,
    input  logic [ARCH_W-1:0]      alloc_arch,
    input  logic [SEQ_W-1:0]       alloc_seq,
    output logic                   alloc_grant,
    output logic [PREG_W-1:0]      alloc_preg,
    output logic                   free_empty,
    output logic [CNT_W-1:0]       free_count,
    input  logic                   squash_valid,
    input  logic [TID_W-1:0]       squash_tid,
    input  logic [SEQ_W-1:0]       squash_seq,
    input  logic [NUM_THREADS-1:0] commit_squashing,
    output logic [NUM_THREADS-1:0] thread_stall,
    input  logic [TID_W-1:0]       lookup_tid,
    input  logic [ARCH_W-1:0]      lookup_arch,
    output logic [PREG_W-1:0]      lookup_preg
);

    logic [NUM_THREADS-1:0]             full_vec;
    logic [NUM_THREADS-1:0]             fire_vec;
    logic [NUM_THREADS-1:0][PREG_W-1:0] look_vec;
    logic [N_REL-1:0]                   rel_valid_all;
    logic [N_REL-1:0][PREG_W-1:0]       rel_preg_all;
    logic                               tid_ok;

    assign tid_ok      = (32'(alloc_tid) < NUM_THREADS);
    assign alloc_grant = alloc_valid && tid_ok && !free_empty
                         && !thread_stall[alloc_tid] && !full_vec[alloc_tid];
    assign lookup_preg = look_vec[lookup_tid];

    rsq_free_list #(
        .NUM_PHYS  (NUM_PHYS),
        .HOME_REGS (NUM_THREADS * NUM_ARCH),
        .N_REL     (N_REL)
    ) u_free (
        .clk       (clk),
        .rst       (rst),
        .take      (alloc_grant),
        .rel_valid (rel_valid_all),
        .rel_preg  (rel_preg_all),
        .head_preg (alloc_preg),
        .empty     (free_empty),
        .count     (free_count)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ctx
        assign fire_vec[t] = alloc_grant && (32'(alloc_tid) == t);

        rsq_thread_ctx #(
            .TID        (t),
            .NUM_ARCH   (NUM_ARCH),
            .NUM_PHYS   (NUM_PHYS),
            .HIST_DEPTH (HIST_DEPTH),
            .DRAIN_W    (DRAIN_W),
            .SEQ_W      (SEQ_W)
        ) u_ctx (
            .clk              (clk),
            .rst              (rst),
            .alloc_fire       (fire_vec[t]),
            .alloc_arch       (alloc_arch),
            .alloc_seq        (alloc_seq),
            .alloc_preg       (alloc_preg),
            .squash_hit       (squash_valid && (32'(squash_tid) == t)),
            .squash_seq       (squash_seq),
            .commit_squashing (commit_squashing[t]),
            .lookup_arch      (lookup_arch),
            .lookup_preg      (look_vec[t]),
            .stall            (thread_stall[t]),
            .hist_full        (full_vec[t]),
            .rel_valid        (rel_valid_all[t*DRAIN_W +: DRAIN_W]),
            .rel_preg         (rel_preg_all[t*DRAIN_W +: DRAIN_W])
        );
    end

    // No grant is issued while the free list reports empty.
    assert_no_grant_when_empty_R3: assert property (@(posedge clk) disable iff (rst)
        free_empty |-> !alloc_grant);

    // A grant removes exactly one register unless drains add some back.
    assert_grant_consumes_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_grant && !(|rel_valid_all)) |=> (free_count == $past(free_count) - 1'b1));

    // Registers parked by a rollback stay unavailable while commit squashes.
    assert_hold_while_squashing_R7: assert property (@(posedge clk) disable iff (rst)
        (!alloc_grant && (commit_squashing == '1)) |=> (free_count == $past(free_count)));

endmodule

// File: tb/sim_rsq_rename_recovery.sv
module sim_rsq_rename_recovery;

    localparam int T = 2, A = 4, P = 15, H = 4, D = 2, SW = 16;

    typedef struct packed {
        logic [SW-1:0] seq;
        logic [1:0]    arch;
        logic [3:0]    prevp;
        logic [3:0]    newp;
    } hent_t;

    logic clk = 1'b0, rst = 1'b1;
    logic alloc_valid = 0, squash_valid = 0;
    logic [0:0] alloc_tid = '0, squash_tid = '0, lookup_tid = '0;
    logic [1:0] alloc_arch = '0, lookup_arch = '0;
    logic [SW-1:0] alloc_seq = '0, squash_seq = '0;
    logic [T-1:0] commit_squashing = '0;
    logic alloc_grant, free_empty;
    logic [3:0] alloc_preg, lookup_preg, free_count;
    logic [T-1:0] thread_stall;

    always #5 clk = ~clk;

    rsq_rename_recovery u0 (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;
    bit mfree [P];
    int mmap [T][A];
    hent_t mhist [T][$];
    int mpend [T][$];
    bit mwalk [T];
    int mpt [T];
    int nseq [T];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // One clock of stimulus: compare at the falling edge, then advance the model.
    task automatic step();
        int lf, cnt;
        bit emp, g;
        bit stl [T];
        @(negedge clk);
        cnt = 0; lf = -1;
        for (int i = P - 1; i >= 0; i--) if (mfree[i]) begin cnt++; lf = i; end
        emp = (cnt == 0);
        for (int t = 0; t < T; t++)
            stl[t] = mwalk[t] || (mpend[t].size() != 0) || (squash_valid && squash_tid == t);
        g = alloc_valid && !emp && !stl[alloc_tid] && (mhist[alloc_tid].size() < H);
        chk(free_empty === emp, "R3 empty flag", int'(free_empty), int'(emp));
        chk(free_count === 4'(cnt), "R6 R7 free count", int'(free_count), cnt);
        chk(alloc_grant === g, "R2 R4 R8 grant", int'(alloc_grant), int'(g));
        if (!emp) chk(alloc_preg === 4'(lf), "R2 lowest free", int'(alloc_preg), lf);
        for (int t = 0; t < T; t++)
            chk(thread_stall[t] === stl[t], "R8 stall", int'(thread_stall[t]), int'(stl[t]));
        chk(lookup_preg === 4'(mmap[lookup_tid][lookup_arch]), "R5 R9 R10 map",
            int'(lookup_preg), mmap[lookup_tid][lookup_arch]);
        // advance model
        for (int t = 0; t < T; t++) begin
            bit hit;
            hit = squash_valid && (squash_tid == t);
            if (mwalk[t]) begin
                if (mhist[t].size() > 0 && int'(mhist[t][$].seq) > mpt[t]) begin
                    hent_t e;
                    e = mhist[t].pop_back();
                    mmap[t][e.arch] = int'(e.prevp);
                    mpend[t].push_back(int'(e.newp));
                end else mwalk[t] = 0;
            end else if (!hit && !commit_squashing[t] && mpend[t].size() > 0) begin
                for (int k = 0; k < D; k++)
                    if (mpend[t].size() > 0) mfree[mpend[t].pop_back()] = 1;
            end
            if (hit) begin
                mwalk[t] = 1;
                mpt[t] = int'(squash_seq);
                nseq[t] = int'(squash_seq) + 1;
            end
        end
        if (g) begin
            mfree[lf] = 0;
            mhist[alloc_tid].push_back('{seq: alloc_seq, arch: alloc_arch,
                prevp: 4'(mmap[alloc_tid][alloc_arch]), newp: 4'(lf)});
            mmap[alloc_tid][alloc_arch] = lf;
            nseq[alloc_tid]++;
        end
        @(posedge clk);
        #1;
        cyc++;
        lookup_tid  = 1'(cyc / A);
        lookup_arch = 2'(cyc);
    endtask

    task automatic drive(input bit av, input int at, input int aa,
                         input bit sv, input int st, input int ss, input int cs);
        alloc_valid = av; alloc_tid = 1'(at); alloc_arch = 2'(aa);
        alloc_seq = SW'(nseq[at]);
        squash_valid = sv; squash_tid = 1'(st); squash_seq = SW'(ss);
        commit_squashing = T'(cs);
    endtask

    initial begin
        for (int i = 0; i < P; i++) mfree[i] = (i >= T * A);
        for (int t = 0; t < T; t++) begin
            for (int a = 0; a < A; a++) mmap[t][a] = t * A + a;
            mwalk[t] = 0; mpt[t] = 0; nseq[t] = 1;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        drive(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(free_count === 4'(P - T * A), "R1 reset free count", int'(free_count), P - T * A);
        chk(thread_stall === '0, "R1 reset stall", int'(thread_stall), 0);
        for (int i = 0; i < T * A; i++) step();
        // R2/R4: thread 0 fills its history, then is refused
        drive(1, 0, 0, 0, 0, 0, 0); step();
        drive(1, 0, 1, 0, 0, 0, 0); step();
        drive(1, 0, 2, 0, 0, 0, 0); step();
        drive(1, 0, 1, 0, 0, 0, 0); step();
        drive(1, 0, 3, 0, 0, 0, 0); step();
        chk(alloc_grant === 1'b0, "R4 full history refused", int'(alloc_grant), 0);
        // R3: thread 1 empties the list, then is refused
        for (int a = 0; a < 3; a++) begin drive(1, 1, a, 0, 0, 0, 0); step(); end
        drive(1, 1, 3, 0, 0, 0, 0); step();
        // R5/R6/R10: squash thread 0 with commit still squashing; thread 1 keeps asking
        drive(1, 1, 3, 1, 0, 2, 1); step();
        drive(1, 1, 3, 0, 0, 0, 1); step();
        drive(1, 1, 3, 1, 0, 0, 1); step();
        for (int i = 0; i < 10; i++) begin drive(1, 1, 3, 0, 0, 0, 1); step(); end
        // R7: release, drains overlap thread 1 renames
        for (int i = 0; i < 6; i++) begin drive(1, 1, 3, 0, 0, 0, 0); step(); end
        // R9: squash thread 1 while thread 0 renames
        drive(1, 0, 2, 1, 1, 0, 0); step();
        for (int i = 0; i < 8; i++) begin drive(1, 0, i % A, 0, 0, 0, 2); step(); end
        for (int i = 0; i < 6; i++) begin drive(0, 0, 0, 0, 0, 0, 0); step(); end
        // Random phase across all requirements
        for (int i = 0; i < 4000; i++) begin
            int at, st, ss;
            bit sv;
            at = $urandom_range(T - 1);
            st = $urandom_range(T - 1);
            sv = ($urandom_range(99) < 5);
            ss = (nseq[st] > 1) ? $urandom_range(nseq[st] - 1) : 0;
            drive($urandom_range(99) < 70, at, $urandom_range(A - 1), sv, st, ss,
                  $urandom_range(3));
            step();
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule